// File: doc/BRIEF.md
# RC Payload Channel Decoder

This block turns the 16-byte data payload of a 2.4 GHz hobby radio-control link into eight servo-style channel values, each given in microseconds. The payload can arrive in either of two ways. One is a byte-wide stream, where a start strobe marks byte 0. The other is a complete 128-bit word presented with a one-cycle valid strobe.

The first four channel slots carry proportional sticks. Each is read as a big-endian 16-bit number and rescaled to a pulse width: the value is multiplied by 1000, divided by 1024 and offset by 1000. The last four slots carry switches. Each follows a single flag bit of byte 12 and sits at either the range minimum or the range maximum. All eight values are registered together, and a one-cycle done pulse marks each fresh decode.

Top module: `rcdec_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first decode, every slot of `ch_out` holds 1000 and `done` is 0.
- R2: A high `par_valid` is decoded from `par_data`, where byte k is `par_data[8k+7:8k]`. `done` is 1 in the cycle that follows the strobe and 0 otherwise, unless another decode completes.
- R3: Slot k of `ch_out` is `ch_out[11k+10:11k]`. Slots 0 to 3 are throttle, roll, pitch and yaw. Slot i takes raw = byte[2i]*256 + byte[2i+1] and outputs floor(raw*1000/1024) + 1000.
- R4: A proportional result above 2047 saturates to 2047. For example, raw 1073 gives 2047 and raw 1074 gives 2047.
- R5: Slots 4 to 7 follow byte 12 bits 0, 1, 2 and 6, in that order. A set bit gives 2000 and a clear bit gives 1000.
- R6: Bytes 13, 14 and 15, and bits 3, 4, 5 and 7 of byte 12, have no effect on any output.
- R7: On the stream port, a byte with `byte_valid` and `byte_sof` both high is byte 0. The next bytes with `byte_valid` high are bytes 1 to 15, and idle cycles may fall between them. `done` rises in the cycle after byte 15 is accepted.
- R8: A start byte in the middle of a frame restarts that frame at byte 0. Valid bytes that arrive while no frame is open are dropped and give no `done`.
- R9: If `par_valid` comes in the same cycle that byte 15 is accepted, the parallel payload is the one decoded and the stream frame is discarded.
- R10: `ch_out` changes only in a cycle where `done` is 1. At all other times it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Stream byte present |
| byte_sof | input | 1 | Marks the stream byte as byte 0 of a frame |
| byte_data | input | 8 | Stream byte |
| par_valid | input | 1 | Parallel payload strobe |
| par_data | input | 128 | Parallel payload, byte k at bits 8k+7:8k |
| ch_out | output | 88 | Eight 11-bit channel slots |
| done | output | 1 | One-cycle pulse for each new decode |

## Verification
The assertions check three things on every cycle. The outputs move only together with `done`. Every `done` comes from an input strobe one cycle earlier. Each slot stays within its legal set, which is 1000 or 2000 for a switch slot and at least 1000 for a proportional slot. The bench covers what depends on the actual bytes. It sweeps the proportional values densely, including both sides of the saturation point, and tries all 256 values of the flag byte. It also runs stream frames with gaps, restarts and stray bytes, and a parallel strobe that collides with a stream completion.

// File: rtl/rcdec_pkg.sv
package rcdec_pkg;
    localparam int PROP_N    = 4;
    localparam int AUX_N     = 4;
    localparam int NCH       = PROP_N + AUX_N;
    localparam int FLAG_BYTE = 12;
    localparam int SCALE_NUM = 1000;
    localparam int SCALE_SH  = 10;
    // bit position inside the flag byte for aux slot k, 3 bits each
    localparam logic [AUX_N*3-1:0] AUX_BITS = {3'd6, 3'd2, 3'd1, 3'd0};
endpackage

// File: rtl/rcdec_asm.sv
module rcdec_asm #(
    parameter int NBYTES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_valid,
    input  logic                  byte_sof,
    input  logic [7:0]            byte_data,
    output logic                  frame_done,
    output logic [8*NBYTES-1:0]   frame
);
    localparam int IDX_W = $clog2(NBYTES);
    localparam int HOLD_W = 8 * (NBYTES - 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [HOLD_W-1:0] hold;
    } asm_t;

    asm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        frame_done = 1'b0;
        frame      = {byte_data, st_q.hold};
        if (byte_valid && byte_sof) begin
            st_d.active    = 1'b1;
            st_d.idx       = IDX_W'(1);
            st_d.hold[7:0] = byte_data;
        end else if (byte_valid && st_q.active) begin
            if (st_q.idx == LAST) begin
                frame_done  = 1'b1;
                st_d.active = 1'b0;
                st_d.idx    = '0;
            end else begin
                st_d.hold[{st_q.idx, 3'b000} +: 8] = byte_data;
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rcdec_scale.sv
module rcdec_scale #(
    parameter int RAW_W     = 16,
    parameter int CH_W      = 11,
    parameter int RANGE_MIN = 1000
) (
    input  logic [RAW_W-1:0] raw,
    output logic [CH_W-1:0]  chan
);
    import rcdec_pkg::*;
    localparam int PROD_W = RAW_W + SCALE_SH;
    localparam int SAT    = (1 << CH_W) - 1;

    logic [PROD_W-1:0] prod, quo, sum;

    always_comb begin
        prod = PROD_W'(raw) * PROD_W'(SCALE_NUM);
        quo  = prod >> SCALE_SH;
        sum  = quo + PROD_W'(RANGE_MIN);
        chan = (sum > PROD_W'(SAT)) ? {CH_W{1'b1}} : sum[CH_W-1:0];
    end
endmodule

// File: rtl/rcdec_map.sv
module rcdec_map #(
    parameter int CH_W      = 11,
    parameter int RANGE_MIN = 1000,
    parameter int RANGE_MAX = 2000,
    parameter int NBYTES    = 16
) (
    input  logic [8*NBYTES-1:0]              payload,
    output logic [rcdec_pkg::NCH*CH_W-1:0]   chans
);
    import rcdec_pkg::*;
    localparam int FB = 8 * FLAG_BYTE;

    for (genvar i = 0; i < PROP_N; i++) begin : g_prop
        logic [15:0] raw;
        assign raw = {payload[16*i +: 8], payload[16*i+8 +: 8]};
        rcdec_scale #(
            .RAW_W(16), .CH_W(CH_W), .RANGE_MIN(RANGE_MIN)
        ) u_scale (
            .raw (raw),
            .chan(chans[i*CH_W +: CH_W])
        );
    end

    for (genvar k = 0; k < AUX_N; k++) begin : g_aux
        localparam int BPOS = int'(AUX_BITS[3*k +: 3]);
        assign chans[(PROP_N+k)*CH_W +: CH_W] =
            payload[FB + BPOS] ? CH_W'(RANGE_MAX) : CH_W'(RANGE_MIN);
    end

    logic unused_payload;
    assign unused_payload = ^{payload[8*NBYTES-1:FB+8], payload[FB+7],
                              payload[FB+5:FB+3]};
endmodule

// File: rtl/rcdec_top.sv
module rcdec_top #(
    parameter int CH_W      = 11,
    parameter int RANGE_MIN = 1000,
    parameter int RANGE_MAX = 2000,
    parameter int NBYTES    = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              byte_valid,
    input  logic                              byte_sof,
    input  logic [7:0]                        byte_data,
    input  logic                              par_valid,
    input  logic [8*NBYTES-1:0]               par_data,
    output logic [rcdec_pkg::NCH*CH_W-1:0]    ch_out,
    output logic                              done
);
    import rcdec_pkg::*;
    localparam int PAY_W = 8 * NBYTES;
    localparam int OUT_W = NCH * CH_W;

    typedef struct packed {
        logic [OUT_W-1:0] ch;
        logic             done;
    } out_t;

    out_t o_d, o_q;
    logic             asm_done;
    logic [PAY_W-1:0] asm_frame, sel_pay;
    logic [OUT_W-1:0] dec_ch;

    rcdec_asm #(.NBYTES(NBYTES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .byte_sof  (byte_sof),
        .byte_data (byte_data),
        .frame_done(asm_done),
        .frame     (asm_frame)
    );

    assign sel_pay = par_valid ? par_data : asm_frame;

    rcdec_map #(
        .CH_W(CH_W), .RANGE_MIN(RANGE_MIN), .RANGE_MAX(RANGE_MAX), .NBYTES(NBYTES)
    ) u_map (
        .payload(sel_pay),
        .chans  (dec_ch)
    );

    always_comb begin
        o_d      = o_q;
        o_d.done = par_valid | asm_done;
        if (par_valid | asm_done) o_d.ch = dec_ch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q.ch   <= {NCH{CH_W'(RANGE_MIN)}};
            o_q.done <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign ch_out = o_q.ch;
    assign done   = o_q.done;
endmodule

// File: rtl/rcdec_chk.sv
module rcdec_chk #(
    parameter int CH_W      = 11,
    parameter int RANGE_MIN = 1000,
    parameter int RANGE_MAX = 2000
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            par_valid,
    input logic                            byte_valid,
    input logic                            done,
    input logic [rcdec_pkg::NCH*CH_W-1:0]  ch_out
);
    import rcdec_pkg::*;

    // R10: outputs move only with a done pulse
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ch_out));

    // R2: every done is caused by an input strobe one cycle earlier
    p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(par_valid || byte_valid));

    // R2: a parallel strobe always yields done next cycle
    p_par_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |=> done);

    for (genvar k = 0; k < AUX_N; k++) begin : g_aux_chk
        // R5: switch slots hold only the two range ends
        p_aux_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_out[(PROP_N+k)*CH_W +: CH_W] == CH_W'(RANGE_MIN)) ||
            (ch_out[(PROP_N+k)*CH_W +: CH_W] == CH_W'(RANGE_MAX)));
    end

    for (genvar i = 0; i < PROP_N; i++) begin : g_prop_chk
        // R3: a proportional slot never drops below the offset
        p_prop_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ch_out[i*CH_W +: CH_W] >= CH_W'(RANGE_MIN));
    end
endmodule

bind rcdec_top rcdec_chk #(
    .CH_W(CH_W), .RANGE_MIN(RANGE_MIN), .RANGE_MAX(RANGE_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_valid (par_valid),
    .byte_valid(byte_valid),
    .done      (done),
    .ch_out    (ch_out)
);

// File: tb/tb_rcdec_top.sv
`timescale 1ns/1ps
module tb_rcdec_top;
    localparam int CH_W = 11;
    localparam int NCH  = 8;
    localparam int OUT_W = NCH * CH_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_valid = 1'b0, byte_sof = 1'b0, par_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic [127:0] par_data = '0;
    logic [OUT_W-1:0] ch_out;
    logic done;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rcdec_top dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
        .byte_data(byte_data), .par_valid(par_valid), .par_data(par_data),
        .ch_out(ch_out), .done(done)
    );

    function automatic int exp_prop(input int raw);
        int v = (raw * 1000) / 1024 + 1000;
        return (v > 2047) ? 2047 : v;
    endfunction

    function automatic logic [OUT_W-1:0] exp_out(input logic [127:0] p);
        logic [OUT_W-1:0] e;
        int bits[4] = '{0, 1, 2, 6};
        for (int i = 0; i < 4; i++) begin
            int raw = int'(p[16*i +: 8]) * 256 + int'(p[16*i+8 +: 8]);
            e[i*CH_W +: CH_W] = CH_W'(exp_prop(raw));
        end
        for (int k = 0; k < 4; k++)
            e[(4+k)*CH_W +: CH_W] = p[96 + bits[k]] ? CH_W'(2000) : CH_W'(1000);
        return e;
    endfunction

    task automatic check_vec(input string tag, input logic [OUT_W-1:0] act,
                             input logic [OUT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs, return at the next falling edge
    task automatic drive(input logic bv, input logic sof, input logic [7:0] d,
                         input logic pv, input logic [127:0] p);
        byte_valid = bv; byte_sof = sof; byte_data = d; par_valid = pv; par_data = p;
        @(negedge clk);
        byte_valid = 0; byte_sof = 0; par_valid = 0;
    endtask

    task automatic send_par(input string tag, input logic [127:0] p);
        drive(0, 0, 8'h00, 1, p);
        check_bit({tag, " done"}, done, 1'b1);
        check_vec(tag, ch_out, exp_out(p));
    endtask

    function automatic logic [127:0] prop_pay(input int r0, r1, r2, r3, input logic [7:0] fl);
        logic [127:0] p = '0;
        int r[4] = '{r0, r1, r2, r3};
        for (int i = 0; i < 4; i++) begin
            p[16*i +: 8]   = r[i][15:8];
            p[16*i+8 +: 8] = r[i][7:0];
        end
        p[96 +: 8] = fl;
        p[104 +: 24] = 24'hA5C3_5A;
        return p;
    endfunction

    // stream a frame; gap inserts idle cycles after each byte
    task automatic send_stream(input string tag, input logic [127:0] p, input int gap);
        for (int k = 0; k < 16; k++) begin
            drive(1, k == 0, p[8*k +: 8], 0, '0);
            if (k < 15) check_bit({tag, " early done"}, done, 1'b0);
            for (int g = 0; g < gap; g++) begin
                drive(0, 0, 8'h00, 0, '0);
                if (k == 15 && g == 0) ;
            end
            if (k == 15 && gap == 0) begin
                check_bit({tag, " done"}, done, 1'b1);
                check_vec(tag, ch_out, exp_out(p));
            end
        end
    endtask

    initial begin
        logic [127:0] p, q;
        logic [OUT_W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_vec("R1 reset ch", ch_out, {NCH{CH_W'(1000)}});
        check_bit("R1 reset done", done, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_vec("R1 post-reset ch", ch_out, {NCH{CH_W'(1000)}});
        check_bit("R1 post-reset done", done, 1'b0);

        // R3/R4: dense sweep through and past the saturation point
        for (int r = 0; r < 512; r++)
            send_par("R3 R4 dense", prop_pay(r*4, r*4+1, r*4+2, r*4+3, 8'(r)));
        // R4: coarse sweep over the whole 16-bit range
        for (int r = 0; r < 1024; r++)
            send_par("R4 wide", prop_pay(r*64, r*64+17, 65535 - r*64, r*3, 8'(r)));
        send_par("R4 edge", prop_pay(1073, 1074, 1023, 0, 8'h00));
        check_vec("R4 edge values", ch_out[4*CH_W-1:0],
                  {CH_W'(1000), CH_W'(1999), CH_W'(2047), CH_W'(2047)});

        // R2: done lasts one cycle; R10: outputs hold while idle
        held = ch_out;
        drive(0, 0, 8'h00, 0, '0);
        check_bit("R2 done width", done, 1'b0);
        repeat (5) @(negedge clk);
        check_vec("R10 hold", ch_out, held);

        // R5: all flag byte values
        for (int b = 0; b < 256; b++)
            send_par("R5 flags", prop_pay(b*3, 700, 1023 - b, 5, 8'(b)));

        // R6: ignored bytes and ignored flag bits
        p = prop_pay(300, 600, 900, 1200, 8'h45);
        send_par("R6 base", p);
        for (int v = 0; v < 32; v++) begin
            q = p;
            q[104 +: 24] = {8'(v*37), 8'(v*91), 8'(~v)};
            q[99] = v[0]; q[100] = v[1]; q[101] = v[2]; q[103] = v[3];
            drive(0, 0, 8'h00, 1, q);
            check_vec("R6 ignored", ch_out, exp_out(p));
        end

        // R7: stream without and with gaps
        send_stream("R7 stream", prop_pay(111, 222, 333, 444, 8'h41), 0);
        p = prop_pay(1000, 20, 4000, 512, 8'h06);
        for (int k = 0; k < 16; k++) begin
            drive(1, k == 0, p[8*k +: 8], 0, '0);
            if (k < 15) begin
                check_bit("R7 gap early done", done, 1'b0);
                drive(0, 0, 8'h00, 0, '0);
                drive(0, 0, 8'h00, 0, '0);
                check_bit("R7 gap idle done", done, 1'b0);
            end
        end
        check_bit("R7 gap done", done, 1'b1);
        check_vec("R7 gap ch", ch_out, exp_out(p));

        // R8: restart mid-frame
        q = prop_pay(9, 8, 7, 6, 8'h00);
        for (int k = 0; k < 6; k++) drive(1, k == 0, q[8*k +: 8], 0, '0);
        p = prop_pay(800, 801, 802, 803, 8'h47);
        send_stream("R8 restart", p, 0);
        // R8: stray bytes with no open frame
        held = ch_out;
        for (int k = 0; k < 20; k++) begin
            drive(1, 0, 8'(k*13), 0, '0);
            check_bit("R8 stray done", done, 1'b0);
        end
        check_vec("R8 stray ch", ch_out, held);

        // R9: parallel strobe collides with stream completion
        q = prop_pay(50, 60, 70, 80, 8'h01);
        p = prop_pay(1500, 1600, 1700, 1800, 8'h42);
        for (int k = 0; k < 15; k++) drive(1, k == 0, q[8*k +: 8], 0, '0);
        drive(1, 0, q[127:120], 1, p);
        check_bit("R9 done", done, 1'b1);
        check_vec("R9 parallel wins", ch_out, exp_out(p));
        drive(1, 0, 8'h33, 0, '0);
        check_bit("R9 frame discarded", done, 1'b0);
        check_vec("R9 hold", ch_out, exp_out(p));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule